// File: doc/BRIEF.md
# TDM Time Slot Interchange Switch

This block is a non-blocking time slot switch for a synchronous serial telecom backplane. Eight serial receive lines and eight serial transmit lines each carry a frame of 32 byte-wide channels. The serial clock runs at twice the bit rate. A frame counter, restarted by a frame pulse, splits every line into bit periods and channel slots. The counter converts each incoming channel to a byte and stores it in a data store that holds two frames. A connection table picks, for each outgoing slot, which of the 256 stored bytes is sent.

Every outgoing byte comes from the frame received just before. Because of this, an input slot can feed any output slot, including an output slot numbered lower than the input slot. A small register port with an 8-bit data bus gives software access to the connection table and to a control register. The control register holds the page that selects which 32 table entries the port can reach, and a transmit drive enable. The drive enable and an external output-enable pin together decide whether the transmit lines are driven.

Top module: `tsi_switch`

## Requirements
- R1: After a synchronous reset the transmit enable `tx_oe` is low, the control register reads 0x00, and connection entry {stream, channel} holds the value {stream[2:0], channel[4:0]}, so every output slot takes the same-numbered input slot.
- R2: A high `frame_p` sampled on a clock edge restarts the frame: the next cycle is the first clock of bit 7 of channel 0 on all lines, whatever the counter held before.
- R3: Each bit spans two clocks and bits go MSB first. A channel is 16 clocks and a frame is 512 clocks, and the counter wraps freely when no pulse arrives. A receive bit is sampled on the second clock of its pair. A transmit bit holds for both clocks of its pair.
- R4: A byte received in input slot {s, c} of one frame is transmitted in the following frame on every output slot whose connection entry equals {s, c}.
- R5: Output slot {stream t, channel k} carries the byte from the input slot held in connection entry {t, k}, coded as bits [7:5] stream and bits [4:0] channel.
- R6: An input byte from channel 31 reaches channel 0 outputs in the very next frame, with no extra frame of delay.
- R7: A port access happens on a clock edge where both `cpu_cs` and `cpu_ds` are high. `cpu_rnw`=0 writes and `cpu_rnw`=1 reads, and read data appears on `cpu_rdata` in the next cycle and holds until the next read. When `cpu_addr[5]` is 0, the access reaches connection entry {page, cpu_addr[4:0]}. When `cpu_addr[5]` is 1, it reaches the control register: bits [2:0] are the page and bit 7 is the drive enable, and bits [6:3] read 0.
- R8: `tx_oe` is high only when `oe_i` is high and the drive enable bit is set.
- R9: Several output slots may name the same input slot, and each of them carries that byte.
- R10: When only one of `cpu_cs` and `cpu_ds` is high, no register or table entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, two cycles per data bit |
| rst | input | 1 | Synchronous reset, active high |
| frame_p | input | 1 | Frame pulse, restarts the frame counter |
| rx_i | input | 8 | Receive serial lines, one bit per line |
| oe_i | input | 1 | External output enable for the transmit lines |
| tx_o | output | 8 | Transmit serial data, one bit per line |
| tx_oe | output | 1 | High when the transmit lines are driven, low for high impedance |
| cpu_cs | input | 1 | Port chip select |
| cpu_ds | input | 1 | Port data strobe |
| cpu_rnw | input | 1 | 1 for a read, 0 for a write |
| cpu_addr | input | 6 | Bit 5 picks the control register, bits 4:0 pick the table entry in the page |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, registered |

## Verification
The sharpest corner is a channel 31 input routed to channel 0 outputs. There the byte is finished and the output slot is loaded on the same clock edge. A design without the forward path would send a byte one frame too old, or the old contents of the store. The bench also restarts the frame from mid-frame and checks that bytes line up to the new pulse, which catches a counter that ignores the pulse or restarts one cycle late. A broadcast of one input to a whole transmit line, and a full permutation across pages, catch paging errors that would write or read the wrong 32 table entries. A strobe with only chip select or only data strobe high must leave the table untouched, so a design that decodes one signal alone fails the read-back.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned DEF_STREAMS = 8;
  localparam int unsigned DEF_CHANS   = 32;
  localparam int unsigned DEF_BITS    = 8;

  // clocks in one frame: two clocks per bit
  function automatic int unsigned frame_len(int unsigned nchan, int unsigned nbits);
    return nchan * nbits * 2;
  endfunction

  // flat slot number of a stream/channel pair
  function automatic int unsigned slot_of(int unsigned stream, int unsigned chan,
                                          int unsigned nchan);
    return stream * nchan + chan;
  endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int NCH = 32,
  parameter int NB  = 8,
  localparam int CNTW = $clog2(NCH * NB * 2),
  localparam int PW   = $clog2(NB) + 1,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fp,
  output logic [CNTW-1:0] cnt,
  output logic            bank,
  output logic            sample_en,
  output logic            byte_end,
  output logic            frame_end,
  output logic            load_en,
  output logic [CHW-1:0]  chan,
  output logic [CHW-1:0]  load_ch
);
  localparam logic [CNTW-1:0] LAST = CNTW'(tsi_pkg::frame_len(NCH, NB) - 1);

  assign chan      = cnt[CNTW-1:PW];
  assign sample_en = cnt[0];
  assign byte_end  = &cnt[PW-1:0];
  assign frame_end = fp || (cnt == LAST);
  assign load_en   = byte_end || fp;
  assign load_ch   = fp ? '0 : chan + CHW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bank <= 1'b0;
    end else if (frame_end) begin
      cnt  <= '0;
      bank <= ~bank;
    end else begin
      cnt <= cnt + CNTW'(1);
    end
  end
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store #(
  parameter int NS  = 8,
  parameter int NCH = 32,
  parameter int NB  = 8,
  localparam int SW  = $clog2(NS),
  localparam int CHW = $clog2(NCH),
  localparam int AW  = SW + CHW
) (
  input  logic                  clk,
  input  logic [NS-1:0]         rx,
  input  logic                  sample_en,
  input  logic                  byte_end,
  input  logic                  bank,
  input  logic [CHW-1:0]        chan,
  input  logic                  rd_cur,
  input  logic                  fwd_en,
  input  logic [NS-1:0][AW-1:0] rd_src,
  output logic [NS-1:0][NB-1:0] rd_byte
);
  logic [NB-1:0]         mem [2*NS*NCH];
  logic [NS-1:0][NB-1:0] sh;
  logic [NS-1:0][NB-1:0] asm_b;

  // byte completed by the bit sampled on this edge
  always_comb
    for (int k = 0; k < NS; k++) asm_b[k] = {sh[k][NB-2:0], rx[k]};

  always_ff @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      if (sample_en) sh[k] <= asm_b[k];
      if (byte_end) mem[{bank, SW'(k), chan}] <= asm_b[k];
    end
  end

  // channel-0 loads read the bank just finishing, forwarding the byte
  // that completes on the same edge
  always_comb begin
    for (int o = 0; o < NS; o++) begin
      if (rd_cur && fwd_en && rd_src[o][CHW-1:0] == chan)
        rd_byte[o] = asm_b[rd_src[o][AW-1:CHW]];
      else
        rd_byte[o] = mem[{rd_cur ? bank : ~bank, rd_src[o]}];
    end
  end
endmodule

// File: rtl/tsi_cmem_port.sv
module tsi_cmem_port #(
  parameter int NS  = 8,
  parameter int NCH = 32,
  parameter int DW  = 8,
  localparam int SW  = $clog2(NS),
  localparam int CHW = $clog2(NCH),
  localparam int AW  = SW + CHW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs,
  input  logic                  ds,
  input  logic                  rnw,
  input  logic [CHW:0]          addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  output logic                  drv_en,
  input  logic [CHW-1:0]        load_ch,
  output logic [NS-1:0][AW-1:0] src
);
  logic [AW-1:0] cm [NS*NCH];
  logic [SW-1:0] page;
  logic [AW-1:0] idx;
  logic [DW-1:0] ctl_rd;
  logic          acc;

  assign acc = cs && ds;
  assign idx = {page, addr[CHW-1:0]};

  always_comb begin
    ctl_rd          = '0;
    ctl_rd[DW-1]    = drv_en;
    ctl_rd[SW-1:0]  = page;
  end

  always_comb
    for (int o = 0; o < NS; o++) src[o] = cm[{SW'(o), load_ch}];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS*NCH; i++) cm[i] <= AW'(i);
      page   <= '0;
      drv_en <= 1'b0;
      rdata  <= '0;
    end else if (acc) begin
      if (rnw)
        rdata <= addr[CHW] ? ctl_rd : DW'(cm[idx]);
      else if (addr[CHW]) begin
        page   <= wdata[SW-1:0];
        drv_en <= wdata[DW-1];
      end else
        cm[idx] <= wdata[AW-1:0];
    end
  end
endmodule

// File: rtl/tsi_tx_out.sv
module tsi_tx_out #(
  parameter int NS = 8,
  parameter int NB = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_en,
  input  logic                  sample_en,
  input  logic [NS-1:0][NB-1:0] ld_byte,
  output logic [NS-1:0]         tx
);
  for (genvar s = 0; s < NS; s++) begin : g_lane
    logic [NB-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst)            sh <= '0;
      else if (load_en)   sh <= ld_byte[s];
      else if (sample_en) sh <= {sh[NB-2:0], 1'b0};
    end
    assign tx[s] = sh[NB-1];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NS  = tsi_pkg::DEF_STREAMS,
  parameter int NCH = tsi_pkg::DEF_CHANS,
  parameter int NB  = tsi_pkg::DEF_BITS,
  parameter int DW  = 8,
  localparam int SW   = $clog2(NS),
  localparam int CHW  = $clog2(NCH),
  localparam int AW   = SW + CHW,
  localparam int CNTW = $clog2(NCH * NB * 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_p,
  input  logic [NS-1:0] rx_i,
  input  logic          oe_i,
  output logic [NS-1:0] tx_o,
  output logic          tx_oe,
  input  logic          cpu_cs,
  input  logic          cpu_ds,
  input  logic          cpu_rnw,
  input  logic [CHW:0]  cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata
);
  logic [CNTW-1:0]        frm_cnt;
  logic                   bank, sample_en, byte_end, frame_end, load_en, drv_en;
  logic [CHW-1:0]         chan, load_ch;
  logic [NS-1:0][AW-1:0]  src;
  logic [NS-1:0][NB-1:0]  ld_byte;

  tsi_timing #(.NCH(NCH), .NB(NB)) u_tim (
    .clk(clk), .rst(rst), .fp(frame_p), .cnt(frm_cnt), .bank(bank),
    .sample_en(sample_en), .byte_end(byte_end), .frame_end(frame_end),
    .load_en(load_en), .chan(chan), .load_ch(load_ch));

  tsi_cmem_port #(.NS(NS), .NCH(NCH), .DW(DW)) u_cm (
    .clk(clk), .rst(rst), .cs(cpu_cs), .ds(cpu_ds), .rnw(cpu_rnw),
    .addr(cpu_addr), .wdata(cpu_wdata), .rdata(cpu_rdata), .drv_en(drv_en),
    .load_ch(load_ch), .src(src));

  tsi_rx_store #(.NS(NS), .NCH(NCH), .NB(NB)) u_rx (
    .clk(clk), .rx(rx_i), .sample_en(sample_en), .byte_end(byte_end),
    .bank(bank), .chan(chan), .rd_cur(frame_end), .fwd_en(byte_end),
    .rd_src(src), .rd_byte(ld_byte));

  tsi_tx_out #(.NS(NS), .NB(NB)) u_tx (
    .clk(clk), .rst(rst), .load_en(load_en), .sample_en(sample_en),
    .ld_byte(ld_byte), .tx(tx_o));

  assign tx_oe = oe_i && drv_en;
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NS   = 8,
  parameter int CNTW = 9,
  parameter int LAST = 511
) (
  input logic            clk,
  input logic            rst,
  input logic            fp,
  input logic            oe_i,
  input logic            tx_oe,
  input logic [NS-1:0]   tx,
  input logic [CNTW-1:0] cnt
);
  AST_FP_RESTART: assert property (@(posedge clk) disable iff (rst)
    fp |=> (cnt == '0)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!fp && cnt == CNTW'(LAST)) |=> (cnt == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!fp && cnt != CNTW'(LAST)) |=> (cnt == $past(cnt) + CNTW'(1))); // R3
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    cnt[0] |-> $stable(tx)); // R3
  AST_HIZ_PIN: assert property (@(posedge clk) disable iff (rst)
    !oe_i |-> !tx_oe); // R8
  AST_RESET_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tx_oe); // R1
endmodule

bind tsi_switch tsi_switch_chk #(.NS(NS), .CNTW(CNTW),
  .LAST(tsi_pkg::frame_len(NCH, NB) - 1)) u_chk (
  .clk(clk), .rst(rst), .fp(frame_p), .oe_i(oe_i), .tx_oe(tx_oe),
  .tx(tx_o), .cnt(frm_cnt));

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_p = 1'b0;
  logic [7:0] rx_i = '0;
  logic       oe_i = 1'b1;
  logic [7:0] tx_o;
  logic       tx_oe;
  logic       cpu_cs = 1'b0, cpu_ds = 1'b0, cpu_rnw = 1'b0;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;

  int checks = 0;
  int errors = 0;
  int pair_bad;
  logic [7:0] in_b [256];
  logic [7:0] prev_b [256];
  logic [7:0] out_b [256];
  logic [7:0] map_b [256];

  always #5 clk = ~clk;

  tsi_switch dut_i (
    .clk(clk), .rst(rst), .frame_p(frame_p), .rx_i(rx_i), .oe_i(oe_i),
    .tx_o(tx_o), .tx_oe(tx_oe), .cpu_cs(cpu_cs), .cpu_ds(cpu_ds),
    .cpu_rnw(cpu_rnw), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [5:0] a, input logic [7:0] d);
    cpu_cs = 1; cpu_ds = 1; cpu_rnw = 0; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_cs = 0; cpu_ds = 0;
  endtask

  task automatic cpu_rd(input logic [5:0] a, output logic [7:0] d);
    cpu_cs = 1; cpu_ds = 1; cpu_rnw = 1; cpu_addr = a;
    @(negedge clk);
    cpu_cs = 0; cpu_ds = 0;
    d = cpu_rdata;
  endtask

  // one frame of 512 clocks; entered and left at a negedge in cycle 0
  task automatic run_frame();
    pair_bad = 0;
    for (int t = 0; t < 512; t++) begin
      int ch;
      int bi;
      ch = t / 16;
      bi = 7 - ((t % 16) / 2);
      for (int s = 0; s < 8; s++) begin
        if (t % 2 == 0) out_b[s*32+ch][bi] = tx_o[s];
        else if (out_b[s*32+ch][bi] != tx_o[s]) pair_bad++;
        rx_i[s] = in_b[s*32+ch][bi];
      end
      frame_p = (t == 511);
      @(negedge clk);
    end
    frame_p = 0;
  endtask

  task automatic resync();
    frame_p = 1;
    @(negedge clk);
    frame_p = 0;
  endtask

  task automatic run_phase(input int seed, input bit ext, input string tag);
    resync();
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 256; i++) in_b[i] = 8'(i * 7 + f * 29 + seed);
      run_frame();
      if (f > 0) begin
        int bad = 0, first = -1, bad6 = 0, bad9 = 0;
        for (int o = 0; o < 256; o++)
          if (out_b[o] !== prev_b[map_b[o]]) begin
            bad++;
            if (first < 0) first = o;
          end
        chk(bad == 0, tag, "routed frame bytes",
            first < 0 ? 0 : int'(out_b[first]),
            first < 0 ? 0 : int'(prev_b[map_b[first]]));
        chk(pair_bad == 0, "R3", "tx bit held two clocks", pair_bad, 0);
        if (ext) begin
          for (int s = 0; s < 7; s++)
            if (out_b[s*32] !== prev_b[map_b[s*32]]) bad6++;
          chk(bad6 == 0, "R6", "ch31 to ch0 next frame", bad6, 0);
          for (int c = 0; c < 32; c++)
            if (out_b[7*32+c] !== prev_b[8'h42]) bad9++;
          chk(bad9 == 0, "R9", "broadcast of one input", bad9, 0);
        end
      end
      for (int i = 0; i < 256; i++) prev_b[i] = in_b[i];
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tx_oe == 0, "R1", "tx_oe after reset", tx_oe, 0);
    cpu_rd(6'h20, d);
    chk(d == 8'h00, "R1", "control after reset", d, 0);
    cpu_rd(6'h05, d);
    chk(d == 8'h05, "R1", "entry {0,5}", d, 8'h05);
    cpu_wr(6'h20, 8'h07);
    cpu_rd(6'h1F, d);
    chk(d == 8'hFF, "R1", "entry {7,31}", d, 8'hFF);
  endtask

  task automatic t_ctl_and_oe();
    logic [7:0] d;
    cpu_wr(6'h20, 8'hFD);
    cpu_rd(6'h20, d);
    chk(d == 8'h85, "R7", "control read masks bits 6:3", d, 8'h85);
    chk(tx_oe == 1, "R8", "tx_oe driven", tx_oe, 1);
    oe_i = 0;
    #1;
    chk(tx_oe == 0, "R8", "tx_oe with pin low", tx_oe, 0);
    oe_i = 1;
    cpu_wr(6'h20, 8'h00);
    #1;
    chk(tx_oe == 0, "R8", "tx_oe with enable clear", tx_oe, 0);
  endtask

  task automatic t_half_strobe();
    logic [7:0] d;
    cpu_cs = 0; cpu_ds = 1; cpu_rnw = 0; cpu_addr = 6'h05; cpu_wdata = 8'hAA;
    @(negedge clk);
    cpu_cs = 1; cpu_ds = 0; cpu_addr = 6'h20; cpu_wdata = 8'h86;
    @(negedge clk);
    cpu_cs = 0;
    cpu_rd(6'h05, d);
    chk(d == 8'h05, "R10", "entry untouched by half strobe", d, 8'h05);
    cpu_rd(6'h20, d);
    chk(d == 8'h00, "R10", "control untouched by half strobe", d, 0);
  endtask

  task automatic t_program_map();
    logic [7:0] d;
    for (int o = 0; o < 256; o++) map_b[o] = 8'(o * 37 + 11);
    for (int s = 0; s < 8; s++) map_b[s*32] = {3'(s ^ 5), 5'd31};
    for (int c = 0; c < 32; c++) map_b[7*32+c] = 8'h42;
    for (int p = 0; p < 8; p++) begin
      cpu_wr(6'h20, 8'h80 | 8'(p));
      for (int c = 0; c < 32; c++) cpu_wr(6'(c), map_b[p*32+c]);
    end
    cpu_wr(6'h20, 8'h83);
    cpu_rd(6'h09, d);
    chk(d == map_b[3*32+9], "R7", "paged entry read-back", d, map_b[3*32+9]);
    cpu_wr(6'h20, 8'h80);
  endtask

  initial begin
    t_reset();
    t_ctl_and_oe();
    t_half_strobe();
    for (int o = 0; o < 256; o++) map_b[o] = 8'(o);
    run_phase(3, 0, "R4");
    t_program_map();
    repeat (77) @(negedge clk);
    run_phase(91, 1, "R5");
    repeat (200) @(negedge clk);
    run_phase(17, 1, "R2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule